// File: doc/BRIEF.md
# Sequential Prefetch Pipelining Controller

This controller sits beside an instruction-fetch bus master and decides whether the line that follows the current fetch may be requested while the bus slave is still streaming data for that fetch. It captures the address and cacheability of each new fetch, waits for the slave to accept the fetch address, lets a minimum number of cycles pass, and then raises a request that carries the next line address. The request is raised only when every gating condition holds: the slave can take an overlapped address, the next line sits in the same 1 KB page, the configuration allows prefetching for this kind of fetch, the current line is still returning, and, for non-cacheable fetches, the next line is neither already buffered nor coming from the tightly coupled memory and no branch or interrupt has redirected the stream.

Addresses are byte addresses. A line is eight 32-bit words (32 bytes) and a page is 1 KB, both set by parameters. Only one overlapped prefetch exists at any time. The controller goes back to idle once its prefetch has been accepted and the overlapped fetch has finished returning data, and only then does it take the next fetch.

Top module: `pfp_ctrl`

## Requirements
- R1: After reset `pf_req` is low and `pf_addr` is zero.
- R2: `pf_addr` equals the captured fetch address with its five low bits cleared plus 32, and stays unchanged while `pf_req` is high.
- R3: With every gate open, `pf_req` rises exactly MIN_GAP (default 2) cycles after the cycle in which `bus_ack` is high, and never sooner. `bus_ack` counts only in a cycle after the one in which `fetch_req` was taken.
- R4: `pf_req` stays high until the cycle in which `pf_ack` is high, then falls, and at most one prefetch is raised per fetch.
- R5: While `slave_pipe_ok` is low no prefetch is raised.
- R6: No prefetch is raised when the next line lies in a different 1 KB page (address bits 31:10 differ). A fetch in the second-to-last line of a page still gets its prefetch.
- R7: For a non-cacheable fetch (`fetch_cacheable`=0) no prefetch is raised when `cfg_nc_line8` is 0 (four-word lines) or `cfg_pf_nc_en` is 0.
- R8: For a cacheable fetch no prefetch is raised when `cfg_pf_cache_en` is 0. The two non-cacheable settings have no effect on cacheable fetches.
- R9: For a non-cacheable fetch the prefetch is held back while `fb_hit` or `tcm_hit` is high and is raised the cycle after both go low. The two hit inputs have no effect on cacheable fetches.
- R10: A `redirect` pulse after the acknowledge and before the prefetch is raised cancels the prefetch for that fetch.
- R11: The prefetch is raised only in a cycle after one where `xfer_active` was high and `xfer_done` low. If `xfer_done` arrives before the prefetch is raised, the prefetch is dropped.
- R12: A `fetch_req` is taken only while idle: one arriving while a prefetch is pending or outstanding is ignored and leaves `pf_addr` unchanged. Once the prefetch is accepted and `xfer_done` has been seen, the next fetch is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | input | 1 | New fetch issued on the bus (taken while idle) |
| fetch_addr | input | ADDR_W | Byte address of the new fetch |
| fetch_cacheable | input | 1 | 1 when the fetch is cacheable |
| bus_ack | input | 1 | Slave accepted the current fetch address |
| xfer_active | input | 1 | Data of the current fetch is being returned |
| xfer_done | input | 1 | Last data beat of the current fetch |
| slave_pipe_ok | input | 1 | Slave accepts an overlapped address |
| cfg_pf_cache_en | input | 1 | Allow prefetch after cacheable fetches |
| cfg_pf_nc_en | input | 1 | Allow prefetch after non-cacheable fetches |
| cfg_nc_line8 | input | 1 | Non-cacheable lines are eight words (0: four words) |
| redirect | input | 1 | Branch or interrupt changed the fetch stream |
| fb_hit | input | 1 | Next line already held in the fill buffer |
| tcm_hit | input | 1 | Next line is served by the tightly coupled memory |
| pf_ack | input | 1 | Bus accepted the prefetch request |
| pf_req | output | 1 | Prefetch request |
| pf_addr | output | ADDR_W | Byte address of the requested line |

## Verification
The bench runs fetches that differ in cacheability, in where the address sits within its page, and in the configuration and slave settings, so that every gate is seen both closed and open. Hit inputs held for several cycles and a late start of data return show that the request waits for the last blocking cycle and does not fire at the fixed gap. Redirect and early completion show cancellation, and a late `pf_ack` together with a stray `fetch_req` during an outstanding prefetch separates holding the request from raising it a second time. Each expected request is placed in a queue with its cycle and address, and the monitor matches every rising `pf_req` against it, so a late, early, missing or extra request is reported.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_ACK,
        ST_GAP,
        ST_PF_OUT
    } pf_state_e;

    // attributes of the captured fetch
    typedef struct packed {
        logic cacheable;
        logic page_cross;
    } fetch_attr_t;

    // one bit per gate; all must be 1 for an issue
    typedef struct packed {
        logic slave;
        logic same_page;
        logic cfg;
        logic streaming;
        logic not_held;
        logic steady;
    } gate_t;

    function automatic logic cfg_allows(input logic cacheable,
                                        input logic c_en,
                                        input logic nc_en,
                                        input logic nc_line8);
        return cacheable ? c_en : (nc_en && nc_line8);
    endfunction

endpackage

// File: rtl/pfp_addr_calc.sv
module pfp_addr_calc
    import pfp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_cacheable,
    output logic [ADDR_W-1:0] next_addr,
    output fetch_attr_t       attr
);
    localparam int PAGE_LSB = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK_N = ~(ADDR_W'(LINE_BYTES) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] PAGE_MASK_N = ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));

    logic [ADDR_W-1:0] nxt_c;
    logic              cross_c;

    always_comb begin
        nxt_c   = (fetch_addr & LINE_MASK_N) + ADDR_W'(LINE_BYTES);
        cross_c = (nxt_c & PAGE_MASK_N) != (fetch_addr & PAGE_MASK_N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_addr <= '0;
            attr      <= '0;
        end else if (capture) begin
            next_addr       <= nxt_c;
            attr.cacheable  <= fetch_cacheable;
            attr.page_cross <= cross_c;
        end
    end
endmodule

// File: rtl/pfp_gate.sv
module pfp_gate
    import pfp_pkg::*;
(
    input  fetch_attr_t attr,
    input  logic        slave_pipe_ok,
    input  logic        cfg_pf_cache_en,
    input  logic        cfg_pf_nc_en,
    input  logic        cfg_nc_line8,
    input  logic        redirect,
    input  logic        fb_hit,
    input  logic        tcm_hit,
    input  logic        xfer_active,
    input  logic        xfer_done,
    output logic        issue_ok
);
    gate_t g;

    always_comb begin
        g.slave     = slave_pipe_ok;
        g.same_page = !attr.page_cross;
        g.cfg       = cfg_allows(attr.cacheable, cfg_pf_cache_en,
                                 cfg_pf_nc_en, cfg_nc_line8);
        g.streaming = xfer_active && !xfer_done;
        // hit inputs only hold back non-cacheable prefetches
        g.not_held  = attr.cacheable || !(fb_hit || tcm_hit);
        g.steady    = !redirect;
        issue_ok    = &g;
    end
endmodule

// File: rtl/pfp_gap_timer.sv
module pfp_gap_timer #(
    parameter int MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic gap_ok
);
    localparam int CNT_W = $clog2(MIN_GAP + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_GAP);
    localparam logic [CNT_W-1:0] READY = CNT_W'(MIN_GAP - 1);

    logic [CNT_W-1:0] cnt;

    // cnt holds the number of cycles elapsed since the acknowledge cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(1);
        end else if (run && cnt < LIMIT) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign gap_ok = run && (cnt >= READY);
endmodule

// File: rtl/pfp_ctrl.sv
module pfp_ctrl
    import pfp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 1024,
    parameter int MIN_GAP    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_cacheable,
    input  logic              bus_ack,
    input  logic              xfer_active,
    input  logic              xfer_done,
    input  logic              slave_pipe_ok,
    input  logic              cfg_pf_cache_en,
    input  logic              cfg_pf_nc_en,
    input  logic              cfg_nc_line8,
    input  logic              redirect,
    input  logic              fb_hit,
    input  logic              tcm_hit,
    input  logic              pf_ack,
    output logic              pf_req,
    output logic [ADDR_W-1:0] pf_addr
);
    pf_state_e   state, state_n;
    fetch_attr_t cap_attr;
    logic        capture, gap_start, gap_ok, issue_ok;
    logic        granted, granted_n, done_seen, done_n;

    pfp_addr_calc #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_addr (
        .clk            (clk),
        .rst            (rst),
        .capture        (capture),
        .fetch_addr     (fetch_addr),
        .fetch_cacheable(fetch_cacheable),
        .next_addr      (pf_addr),
        .attr           (cap_attr)
    );

    pfp_gate u_gate (
        .attr           (cap_attr),
        .slave_pipe_ok  (slave_pipe_ok),
        .cfg_pf_cache_en(cfg_pf_cache_en),
        .cfg_pf_nc_en   (cfg_pf_nc_en),
        .cfg_nc_line8   (cfg_nc_line8),
        .redirect       (redirect),
        .fb_hit         (fb_hit),
        .tcm_hit        (tcm_hit),
        .xfer_active    (xfer_active),
        .xfer_done      (xfer_done),
        .issue_ok       (issue_ok)
    );

    pfp_gap_timer #(
        .MIN_GAP(MIN_GAP)
    ) u_gap (
        .clk   (clk),
        .rst   (rst),
        .start (gap_start),
        .run   (state == ST_GAP),
        .gap_ok(gap_ok)
    );

    assign pf_req = (state == ST_PF_OUT) && !granted;

    always_comb begin
        state_n   = state;
        capture   = 1'b0;
        gap_start = 1'b0;
        granted_n = granted;
        done_n    = done_seen;
        unique case (state)
            ST_IDLE: begin
                if (fetch_req) begin
                    capture = 1'b1;
                    state_n = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (redirect) begin
                    state_n = ST_IDLE;
                end else if (bus_ack) begin
                    gap_start = 1'b1;
                    state_n   = ST_GAP;
                end
            end
            ST_GAP: begin
                if (redirect || xfer_done) begin
                    state_n = ST_IDLE;
                end else if (gap_ok && issue_ok) begin
                    granted_n = 1'b0;
                    done_n    = 1'b0;
                    state_n   = ST_PF_OUT;
                end
            end
            ST_PF_OUT: begin
                granted_n = granted | (pf_ack & pf_req);
                done_n    = done_seen | xfer_done;
                if (granted_n && done_n) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            granted   <= 1'b0;
            done_seen <= 1'b0;
        end else begin
            state     <= state_n;
            granted   <= granted_n;
            done_seen <= done_n;
        end
    end
endmodule

// File: rtl/pfp_ctrl_chk.sv
module pfp_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_ack,
    input logic              xfer_active,
    input logic              xfer_done,
    input logic              slave_pipe_ok,
    input logic              cfg_pf_cache_en,
    input logic              cfg_pf_nc_en,
    input logic              cfg_nc_line8,
    input logic              redirect,
    input logic              fb_hit,
    input logic              tcm_hit,
    input logic              pf_ack,
    input logic              pf_req,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              cur_cach
);
    localparam int LINE_LSB = $clog2(LINE_BYTES);
    localparam int PAGE_LSB = $clog2(PAGE_BYTES);

    p_line_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        pf_req |-> (pf_addr[LINE_LSB-1:0] == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (pf_req && !pf_ack) |=> (pf_req && $stable(pf_addr)));

    p_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_req) |-> !$past(bus_ack));

    p_single_r4: assert property (@(posedge clk) disable iff (rst)
        (pf_req && pf_ack) |=> !pf_req);

    p_slave_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_req) |-> $past(slave_pipe_ok));

    // a next line that starts a page has crossed into it
    p_page_r6: assert property (@(posedge clk) disable iff (rst)
        pf_req |-> (pf_addr[PAGE_LSB-1:0] != '0));

    p_nc_cfg_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(pf_req) && !cur_cach) |-> $past(cfg_pf_nc_en && cfg_nc_line8));

    p_c_cfg_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(pf_req) && cur_cach) |-> $past(cfg_pf_cache_en));

    p_hits_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(pf_req) && !cur_cach) |-> $past(!fb_hit && !tcm_hit));

    p_redirect_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_req) |-> !$past(redirect));

    p_stream_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_req) |-> $past(xfer_active && !xfer_done));
endmodule

bind pfp_ctrl pfp_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .PAGE_BYTES(PAGE_BYTES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_ack        (bus_ack),
    .xfer_active    (xfer_active),
    .xfer_done      (xfer_done),
    .slave_pipe_ok  (slave_pipe_ok),
    .cfg_pf_cache_en(cfg_pf_cache_en),
    .cfg_pf_nc_en   (cfg_pf_nc_en),
    .cfg_nc_line8   (cfg_nc_line8),
    .redirect       (redirect),
    .fb_hit         (fb_hit),
    .tcm_hit        (tcm_hit),
    .pf_ack         (pf_ack),
    .pf_req         (pf_req),
    .pf_addr        (pf_addr),
    .cur_cach       (cap_attr.cacheable)
);

// File: tb/tb_pfp_ctrl.sv
`timescale 1ns/1ps
module tb_pfp_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 0, fetch_cacheable = 0, bus_ack = 0;
    logic [31:0] fetch_addr = '0;
    logic        xfer_active = 0, xfer_done = 0, slave_pipe_ok = 1;
    logic        cfg_pf_cache_en = 1, cfg_pf_nc_en = 1, cfg_nc_line8 = 1;
    logic        redirect = 0, fb_hit = 0, tcm_hit = 0, pf_ack = 0;
    logic        pf_req;
    logic [31:0] pf_addr;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit done_flag = 0;

    typedef struct {
        logic [31:0] addr;
        int          at;
        string       tag;
    } exp_t;
    exp_t exq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pfp_ctrl dut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_cacheable(fetch_cacheable), .bus_ack(bus_ack),
        .xfer_active(xfer_active), .xfer_done(xfer_done),
        .slave_pipe_ok(slave_pipe_ok), .cfg_pf_cache_en(cfg_pf_cache_en),
        .cfg_pf_nc_en(cfg_pf_nc_en), .cfg_nc_line8(cfg_nc_line8),
        .redirect(redirect), .fb_hit(fb_hit), .tcm_hit(tcm_hit),
        .pf_ack(pf_ack), .pf_req(pf_req), .pf_addr(pf_addr)
    );

    task automatic check(input bit ok, input string what, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %s expected %s", what, act, exp);
        end
    endtask

    // monitor: every rising pf_req must match the head of the queue
    logic prev_req = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pf_req && !prev_req) begin
                if (exq.size() == 0) begin
                    check(0, "unexpected prefetch (R4/R5-R11)",
                          $sformatf("req addr=%h cyc=%0d", pf_addr, cyc), "no request");
                end else begin
                    exp_t e;
                    e = exq.pop_front();
                    check(pf_addr == e.addr, {e.tag, " address"},
                          $sformatf("%h", pf_addr), $sformatf("%h", e.addr));
                    check(cyc == e.at, {e.tag, " issue cycle"},
                          $sformatf("%0d", cyc), $sformatf("%0d", e.at));
                end
            end
            prev_req <= pf_req;
        end
    end

    task automatic set_cfg(input bit pipe, input bit c_en, input bit nc_en, input bit nc8);
        slave_pipe_ok = pipe; cfg_pf_cache_en = c_en; cfg_pf_nc_en = nc_en; cfg_nc_line8 = nc8;
    endtask

    // offsets k count cycles after the acknowledge cycle
    task automatic run_fetch(input logic [31:0] addr, input bit cach,
                             input bit hit_tcm, input int hold_hit,
                             input int redir_at, input int act_from,
                             input int done_at, input int ack_from,
                             input int stray_at, input bit expect_pf,
                             input int exp_off, input string tag);
        int a;
        exp_t e;
        @(posedge clk); #1;
        fetch_req = 1; fetch_addr = addr; fetch_cacheable = cach;
        @(posedge clk); #1;
        fetch_req = 0; fetch_addr = 32'hDEAD_BEE0;
        bus_ack = 1;
        a = cyc;
        xfer_active = (act_from == 0);
        fb_hit  = !hit_tcm && (hold_hit > 0);
        tcm_hit =  hit_tcm && (hold_hit > 0);
        if (expect_pf) begin
            e.addr = (addr & ~32'h1F) + 32'h20;
            e.at   = a + exp_off;
            e.tag  = tag;
            exq.push_back(e);
        end
        for (int k = 1; k <= done_at; k++) begin
            @(posedge clk); #1;
            bus_ack     = 0;
            xfer_active = (k >= act_from);
            fb_hit      = !hit_tcm && (k < hold_hit);
            tcm_hit     =  hit_tcm && (k < hold_hit);
            redirect    = (k == redir_at);
            xfer_done   = (k == done_at);
            fetch_req   = (k == stray_at);
            fetch_addr  = (k == stray_at) ? 32'h0000_7700 : 32'hDEAD_BEE0;
            if (ack_from > 3 && k == ack_from - 1)
                check(pf_req === 1'b1 && pf_addr == (addr & ~32'h1F) + 32'h20,
                      "R4 request held until accepted",
                      $sformatf("req=%b addr=%h", pf_req, pf_addr), "req=1 same addr");
            pf_ack = pf_req && (k >= ack_from);
        end
        @(posedge clk); #1;
        xfer_active = 0; xfer_done = 0; redirect = 0; fetch_req = 0;
        fb_hit = 0; tcm_hit = 0; pf_ack = 0;
        repeat (3) @(posedge clk);
        #1;
        check(exq.size() == 0, {tag, " expected request seen"},
              $sformatf("%0d missing", exq.size()), "0 missing");
        exq.delete();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(pf_req === 1'b0 && pf_addr === 32'h0, "R1 reset state",
              $sformatf("req=%b addr=%h", pf_req, pf_addr), "req=0 addr=0");
        rst = 0;
        repeat (2) @(posedge clk);

        // R2 R3 cacheable, all gates open
        run_fetch(32'h0000_1204, 1, 0, 0, 0, 0, 6, 0, 0, 1, 2, "R2/R3 cacheable");
        // R7 non-cacheable allowed
        run_fetch(32'h0000_2008, 0, 0, 0, 0, 0, 6, 0, 0, 1, 2, "R7 nc allowed");
        // R5 slave cannot pipeline
        set_cfg(0, 1, 1, 1);
        run_fetch(32'h0000_3000, 1, 0, 0, 0, 0, 6, 0, 0, 0, 0, "R5 slave blocks");
        set_cfg(1, 1, 1, 1);
        // R6 page crossing and the line before it
        run_fetch(32'h0000_13E4, 1, 0, 0, 0, 0, 6, 0, 0, 0, 0, "R6 page cross");
        run_fetch(32'h0000_13C4, 0, 0, 0, 0, 0, 6, 0, 0, 1, 2, "R6 last line in page");
        // R7 four-word lines, nc disabled
        set_cfg(1, 1, 1, 0);
        run_fetch(32'h0000_4010, 0, 0, 0, 0, 0, 6, 0, 0, 0, 0, "R7 four-word lines");
        set_cfg(1, 1, 0, 1);
        run_fetch(32'h0000_4030, 0, 0, 0, 0, 0, 6, 0, 0, 0, 0, "R7 nc disabled");
        // R8 cacheable disabled, nc settings irrelevant for cacheable
        set_cfg(1, 0, 1, 1);
        run_fetch(32'h0000_5000, 1, 0, 0, 0, 0, 6, 0, 0, 0, 0, "R8 c disabled");
        set_cfg(1, 1, 0, 0);
        run_fetch(32'h0000_5040, 1, 0, 0, 0, 0, 6, 0, 0, 1, 2, "R8 nc cfg ignored");
        set_cfg(1, 1, 1, 1);
        // R9 hits hold nc prefetch, ignored for cacheable
        run_fetch(32'h0000_6000, 0, 0, 4, 0, 0, 8, 0, 0, 1, 5, "R9 fill buffer hold");
        run_fetch(32'h0000_6100, 0, 1, 4, 0, 0, 8, 0, 0, 1, 5, "R9 tcm hold");
        run_fetch(32'h0000_6200, 1, 0, 10, 0, 0, 8, 0, 0, 1, 2, "R9 hit ignored cacheable");
        // R10 redirect cancels
        run_fetch(32'h0000_7000, 1, 0, 0, 1, 0, 6, 0, 0, 0, 0, "R10 redirect c");
        run_fetch(32'h0000_7100, 0, 0, 0, 1, 0, 6, 0, 0, 0, 0, "R10 redirect nc");
        // R11 late data start, early completion
        run_fetch(32'h0000_8000, 1, 0, 0, 0, 3, 8, 0, 0, 1, 4, "R11 late stream");
        run_fetch(32'h0000_8100, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R11 done first");
        // R4 held until late accept, R12 stray fetch ignored then next fetch served
        run_fetch(32'h0000_9000, 1, 0, 0, 0, 0, 8, 5, 3, 1, 2, "R4 late accept");
        run_fetch(32'h0000_9100, 0, 0, 0, 0, 0, 8, 0, 4, 1, 2, "R12 stray ignored");
        run_fetch(32'h0000_A020, 1, 0, 0, 0, 0, 6, 0, 0, 1, 2, "R12 next fetch");

        finish_run();
    end
endmodule